// File: doc/BRIEF.md
# Serial Digital Video Line Encoder

This block turns a stream of 10-bit parallel video words into a single serial line bit, ready for a coaxial cable driver. It runs on the bit-rate clock, which is ten times the word rate (a 27 MHz word rate gives 270 Mb/s). A one-cycle strobe, asserted once every tenth bit-clock cycle, marks the cycle in which a new word is presented.

Each strobed word is captured in an input register. Before capture, the word passes through a sync-aware conditioner, so that timing-reference preamble words come out at their full 10-bit values even when the source only carries 8 significant bits. The captured word is then sent one bit per clock, least significant bit first. Each bit goes through a self-synchronizing scrambler built on x^9 + x^4 + 1 and then through an NRZI coder built on x + 1. The resulting line signal has little DC content and enough transitions for the receiver to recover the clock.

Top module: `sdi_line_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the scrambler history, the NRZI state, the captured word and the bit index are all cleared, so `ser_out` is 0 after that edge. With no strobe after reset, `ser_out` stays 0.
- R2: With `mode_8b` = 0 (10-bit source), the captured word equals `word_in` exactly.
- R3: With `mode_8b` = 1 and `word_in[9:2]` all ones, the captured word is 10'h3FF, whatever `word_in[1:0]` holds.
- R4: With `mode_8b` = 1 and `word_in[9:2]` all zeros, the captured word is 10'h000, whatever `word_in[1:0]` holds.
- R5: With `mode_8b` = 1 and any other value in `word_in[9:2]`, the captured word is `{word_in[9:2], 2'b00}`.
- R6: Bits of a captured word are sent least significant bit first. Bit 0 is presented to the scrambler in the cycle that follows the strobe edge, and bit k is presented k cycles later.
- R7: The scrambled bit is the current NRZ bit XORed with the scrambled bits from 4 and 9 cycles earlier. Those earlier values count as 0 when they fall before reset.
- R8: `ser_out` toggles at a clock edge when the scrambled bit is 1, and holds when it is 0.
- R9: A line bit reaches `ser_out` one clock edge after the cycle in which it is presented to the scrambler, so bit 0 of a word first shows on `ser_out` after the second edge counted from the strobe edge.
- R10: If no strobe arrives after ten bits, the bit index wraps to 0 and the same captured word is sent again.
- R11: A reset asserted in the middle of a word restarts the whole chain from its cleared state, and later words are encoded exactly as they are after power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_stb | input | 1 | Word strobe: capture `word_in` at this edge (one cycle in ten) |
| mode_8b | input | 1 | 1: source carries 8 significant bits in `word_in[9:2]`; 0: full 10-bit source |
| word_in | input | 10 | Parallel video word |
| ser_out | output | 1 | Scrambled NRZI line bit |

## Verification
The bench sends every 10-bit code in full-resolution mode, and every 8-bit code with the two low bits set to changing junk in 8-bit mode. This separates the pass-through, all-ones, all-zeros and padding paths of the conditioner. Each word is recovered at the port by a software NRZI decoder and descrambler and compared whole, so a wrong bit order, a wrong tap or a wrong conditioning shows up as a wrong word. The line bit is also compared cycle by cycle with an arithmetic model of the line code. Runs with no strobe, a quiet post-reset period and a reset in mid-word cover the wrap-around and the cleared state.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;

   // Default geometry of the line encoder
   localparam int unsigned DEF_WORD_W  = 10;
   localparam int unsigned DEF_SRC_W   = 8;
   localparam int unsigned DEF_SCR_LEN = 9;
   localparam int unsigned DEF_SCR_TAP = 4;

   // Resolution of the parallel source
   typedef enum logic {
      RES_FULL    = 1'b0,
      RES_REDUCED = 1'b1
   } src_res_e;

endpackage

// File: rtl/sdi_word_latch.sv
module sdi_word_latch
   import sdi_enc_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter int unsigned SRC_W  = DEF_SRC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  src_res_e          res,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] cond_word,
   output logic [WORD_W-1:0] word_q
);

   localparam int unsigned PAD_W = WORD_W - SRC_W;

   logic [SRC_W-1:0] hi_part;

   assign hi_part = word_in[WORD_W-1 -: SRC_W];

   // Sync-aware conditioning of reduced-resolution words
   always_comb begin
      if (res == RES_FULL) begin
         cond_word = word_in;
      end else if (&hi_part) begin
         cond_word = '1;
      end else if (~|hi_part) begin
         cond_word = '0;
      end else begin
         cond_word = {hi_part, {PAD_W{1'b0}}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= cond_word;
      end
   end

endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer #(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_q,
   output logic              nrz_bit
);

   localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   logic [IDX_W-1:0] bit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_idx <= '0;
      end else if (load || (bit_idx == LAST_IDX)) begin
         bit_idx <= '0;
      end else begin
         bit_idx <= bit_idx + 1'b1;
      end
   end

   // Least significant bit goes out first
   assign nrz_bit = word_q[bit_idx];

endmodule

// File: rtl/sdi_scrambler.sv
module sdi_scrambler #(
   parameter int unsigned SCR_LEN = 9,
   parameter int unsigned SCR_TAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nrz_bit,
   output logic scr_bit
);

   logic [SCR_LEN-1:0] hist;

   assign scr_bit = nrz_bit ^ hist[SCR_TAP-1] ^ hist[SCR_LEN-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist[0] <= 1'b0;
      end else begin
         hist[0] <= scr_bit;
      end
   end

   for (genvar i = 1; i < SCR_LEN; i++) begin : g_hist
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hist[i] <= 1'b0;
         end else begin
            hist[i] <= hist[i-1];
         end
      end
   end

endmodule

// File: rtl/sdi_nrzi.sv
module sdi_nrzi (
   input  logic clk,
   input  logic rst_n,
   input  logic scr_bit,
   output logic line_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= 1'b0;
      end else begin
         line_q <= line_q ^ scr_bit;
      end
   end

endmodule

// File: rtl/sdi_line_encoder.sv
module sdi_line_encoder
   import sdi_enc_pkg::*;
#(
   parameter int unsigned WORD_W  = DEF_WORD_W,
   parameter int unsigned SRC_W   = DEF_SRC_W,
   parameter int unsigned SCR_LEN = DEF_SCR_LEN,
   parameter int unsigned SCR_TAP = DEF_SCR_TAP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_stb,
   input  logic              mode_8b,
   input  logic [WORD_W-1:0] word_in,
   output logic              ser_out
);

   if (SRC_W == 0 || SRC_W >= WORD_W) begin : g_bad_src
      $error("sdi_line_encoder: SRC_W must lie in 1..WORD_W-1");
   end
   if (SCR_TAP == 0 || SCR_TAP >= SCR_LEN) begin : g_bad_tap
      $error("sdi_line_encoder: SCR_TAP must lie in 1..SCR_LEN-1");
   end

   src_res_e          res_sel;
   logic [WORD_W-1:0] cond_word;
   logic [WORD_W-1:0] word_q;
   logic              nrz_bit;
   logic              scr_bit;

   assign res_sel = mode_8b ? RES_REDUCED : RES_FULL;

   sdi_word_latch #(
      .WORD_W (WORD_W),
      .SRC_W  (SRC_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (word_stb),
      .res       (res_sel),
      .word_in   (word_in),
      .cond_word (cond_word),
      .word_q    (word_q)
   );

   sdi_serializer #(
      .WORD_W (WORD_W)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (word_stb),
      .word_q  (word_q),
      .nrz_bit (nrz_bit)
   );

   sdi_scrambler #(
      .SCR_LEN (SCR_LEN),
      .SCR_TAP (SCR_TAP)
   ) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .nrz_bit (nrz_bit),
      .scr_bit (scr_bit)
   );

   sdi_nrzi u_nrzi (
      .clk     (clk),
      .rst_n   (rst_n),
      .scr_bit (scr_bit),
      .line_q  (ser_out)
   );

endmodule

// File: rtl/sdi_line_encoder_chk.sv
module sdi_line_encoder_chk #(
   parameter int unsigned WORD_W  = 10,
   parameter int unsigned SRC_W   = 8,
   parameter int unsigned SCR_LEN = 9,
   parameter int unsigned SCR_TAP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_stb,
   input logic              mode_8b,
   input logic [WORD_W-1:0] word_in,
   input logic [WORD_W-1:0] cond_word,
   input logic [WORD_W-1:0] word_q,
   input logic              nrz_bit,
   input logic              scr_bit,
   input logic              ser_out
);

   localparam int unsigned PAD_W = WORD_W - SRC_W;

   logic [SRC_W-1:0] hi_in;
   logic [4:0]       since_rst;

   assign hi_in = word_in[WORD_W-1 -: SRC_W];

   // Cycles since reset release, saturating
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
      end else if (since_rst != 5'd31) begin
         since_rst <= since_rst + 1'b1;
      end
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> !ser_out);

   a_r2_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && !mode_8b) |=> (word_q == $past(word_in)));

   a_r3_trs_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && mode_8b && (&hi_in)) |=> (&word_q));

   a_r4_trs_zeros: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && mode_8b && !(|hi_in)) |=> (word_q == '0));

   a_r5_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && mode_8b) |=> (word_q[PAD_W-1:0] == '0 || (&word_q)));

   a_r6_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> (nrz_bit == $past(cond_word[0])));

   a_r7_scramble: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 5'(SCR_LEN)) |->
      (scr_bit == (nrz_bit ^ $past(scr_bit, SCR_TAP) ^ $past(scr_bit, SCR_LEN))));

   a_r8_nrzi_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      scr_bit |=> (ser_out != $past(ser_out)));

   a_r8_nrzi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !scr_bit |=> $stable(ser_out));

endmodule

bind sdi_line_encoder sdi_line_encoder_chk #(
   .WORD_W  (WORD_W),
   .SRC_W   (SRC_W),
   .SCR_LEN (SCR_LEN),
   .SCR_TAP (SCR_TAP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .word_stb  (word_stb),
   .mode_8b   (mode_8b),
   .word_in   (word_in),
   .cond_word (cond_word),
   .word_q    (word_q),
   .nrz_bit   (nrz_bit),
   .scr_bit   (scr_bit),
   .ser_out   (ser_out)
);

// File: tb/sdi_line_encoder_test.sv
module sdi_line_encoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       word_stb = 1'b0;
   logic       mode_8b = 1'b0;
   logic [9:0] word_in = '0;
   logic       ser_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // Line-code model state
   logic [9:0] m_word;
   int         m_idx;
   logic [8:0] m_hist;
   logic       m_line;
   string      m_label;
   // Receiver state
   logic       r_prev;
   logic [8:0] r_hist;
   logic [9:0] r_word;
   int         p_idx;
   logic [9:0] p_word;
   string      p_label;
   bit         rx_on;

   sdi_line_encoder uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_stb (word_stb),
      .mode_8b  (mode_8b),
      .word_in  (word_in),
      .ser_out  (ser_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, actual=expired expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic logic [9:0] cond(input logic [9:0] w, input logic m8);
      if (!m8)               return w;
      if (w[9:2] == 8'hFF)   return 10'h3FF;
      if (w[9:2] == 8'h00)   return 10'h000;
      return {w[9:2], 2'b00};
   endfunction

   task automatic check(input string lbl, input logic [9:0] act, input logic [9:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", lbl, act, exp);
      end
   endtask

   task automatic clear_model();
      m_word = '0; m_idx = 0; m_hist = '0; m_line = 1'b0; m_label = "R1";
      r_prev = 1'b0; r_hist = '0; r_word = '0; p_idx = -1; p_word = '0;
      p_label = "R1";
   endtask

   // One bit-clock cycle; called at a falling edge with inputs to drive
   task automatic step(input logic stb, input logic [9:0] w, input logic m8);
      logic s_rx, d_rx, d, s;
      word_stb = stb; word_in = w; mode_8b = m8;
      // Compare line with model (R7 R8 R9)
      check("R7/R8/R9 line bit", {9'b0, ser_out}, {9'b0, m_line});
      // Receiver: NRZI decode then descramble
      s_rx = ser_out ^ r_prev;
      r_prev = ser_out;
      d_rx = s_rx ^ r_hist[3] ^ r_hist[8];
      r_hist = {r_hist[7:0], s_rx};
      if (p_idx >= 0) begin
         r_word[p_idx] = d_rx;
         if (p_idx == 9 && rx_on) check({p_label, " recovered word"}, r_word, p_word);
      end
      // Model of the coming edge
      if (!rst_n) begin
         clear_model();
      end else begin
         d = m_word[m_idx];
         s = d ^ m_hist[3] ^ m_hist[8];
         m_hist = {m_hist[7:0], s};
         m_line = m_line ^ s;
         p_idx = m_idx; p_word = m_word; p_label = m_label;
         if (stb) begin
            m_word = cond(w, m8); m_idx = 0;
            if (!m8)                 m_label = "R2/R6";
            else if (w[9:2] == 8'hFF) m_label = "R3";
            else if (w[9:2] == 8'h00) m_label = "R4";
            else                      m_label = "R5";
         end else begin
            m_idx = (m_idx + 1) % 10;
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [9:0] w, input logic m8);
      step(1'b1, w, m8);
      for (int k = 0; k < 9; k++) step(1'b0, w ^ 10'h155, m8);
   endtask

   initial begin
      clear_model();
      rx_on = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 3; k++) step(1'b0, 10'h2AA, 1'b0);
      check("R1 ser_out in reset", {9'b0, ser_out}, 10'h000);
      rst_n = 1'b1;
      // R1: quiet after reset
      for (int k = 0; k < 20; k++) begin
         check("R1 idle line", {9'b0, ser_out}, 10'h000);
         step(1'b0, 10'h3FF, 1'b0);
      end
      // R2 R6: every 10-bit code
      for (int v = 0; v < 1024; v++) send(10'(v), 1'b0);
      // R3 R4 R5: every 8-bit code with junk in the low bits
      for (int v = 0; v < 256; v++) send({8'(v), 2'(v ^ 3)}, 1'b1);
      // TRS preamble in 8-bit mode
      send(10'h3FE, 1'b1); send(10'h001, 1'b1); send(10'h002, 1'b1); send(10'h2D3, 1'b1);
      // R10: no strobe, word repeats
      send(10'h1C5, 1'b0);
      m_label = "R10";
      for (int k = 0; k < 10; k++) step(1'b0, 10'h000, 1'b0);
      m_label = "R10";
      for (int k = 0; k < 10; k++) step(1'b0, 10'h3FF, 1'b1);
      // R11: reset in mid-word
      step(1'b1, 10'h36C, 1'b0);
      for (int k = 0; k < 4; k++) step(1'b0, 10'h000, 1'b0);
      rst_n = 1'b0;
      rx_on = 1'b0;
      for (int k = 0; k < 2; k++) step(1'b0, 10'h000, 1'b0);
      check("R11 ser_out after mid-word reset", {9'b0, ser_out}, 10'h000);
      rst_n = 1'b1;
      rx_on = 1'b1;
      for (int k = 0; k < 5; k++) begin
         check("R11 idle after reset", {9'b0, ser_out}, 10'h000);
         step(1'b0, 10'h3FF, 1'b0);
      end
      send(10'h36C, 1'b0);
      m_label = "R11";
      send(10'h0F1, 1'b0);
      send(10'h3FF, 1'b1);
      for (int k = 0; k < 11; k++) step(1'b0, 10'h000, 1'b0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule